// File: doc/BRIEF.md
# Up/down event timer with prescaler

This block is an eight-bit timer counter whose count source and count direction come from a small mode register. The count source is one of six taps of a free-running 13-bit prescaler on the system clock, a sub-clock enable pulse already synchronous to the system clock, or a chosen edge of an asynchronous external event input. The direction is fixed up, fixed down, or handed at run time to an asynchronous up/down pin.

Software writes the mode register through a one-cycle write strobe. It reads either the mode register or the live counter value through a one-bit read address. The counter wraps in both directions. Each wrap sets a sticky interrupt flag, which stays set until a clear strobe is pulsed. Reset is active low and asynchronous. Its release is expected to be synchronized to `clk` upstream of the block.

Top module: `updn_event_timer`

## Requirements
- R1: After reset the mode register reads 0x18 (direction up, source prescaler/8192), the counter reads 0x00 and `irq_flag` is low.
- R2: Mode register bits: [2:0] source select, [6:5] direction. Bits [4:3] always read 1 and bit 7 always reads 0, and writes to those three bits are ignored. A write with `wr_en` high is seen on `rd_data` (with `rd_addr`=0) from the next cycle.
- R3: Direction 00 counts up by one per count enable. Direction 01 counts down by one per count enable.
- R4: Direction 10 or 11 takes the direction from `ud_pin` after a two-flop synchronizer: high counts down and low counts up. A pin change applies to count enables from the third rising edge after the change onward.
- R5: Source codes 000 to 101 divide the system clock by 8192, 2048, 512, 64, 16 and 4. The prescaler is 0 after reset and increments every edge. The counter advances on each edge at which the prescaler's low log2(N) bits are all ones, so divide-by-8192 first advances the counter on the 8192nd edge after reset.
- R6: Source code 110 advances the counter on every edge at which `subclk_en` is high.
- R7: Source code 111 counts edges of `ext_evt`: rising edges when `evt_rise`=1 and falling edges when it is 0. An input change is counted on the third rising edge after it.
- R8: Counting up from 0xFF gives 0x00 and counting down from 0x00 gives 0xFF. Either wrap sets `irq_flag` on the same edge.
- R9: `irq_flag` stays set until an edge with `flag_clr` high, which clears it. If a wrap and `flag_clr` fall on the same edge, the flag is set.
- R10: With no count enable the counter holds its value. `rd_addr`=1 reads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| rd_addr | input | 1 | Read select: 0 mode register, 1 counter |
| rd_data | output | 8 | Read value (combinational from `rd_addr`) |
| flag_clr | input | 1 | Clear strobe for the wrap flag |
| ext_evt | input | 1 | Asynchronous external event input |
| evt_rise | input | 1 | Event edge select: 1 rising, 0 falling |
| ud_pin | input | 1 | Asynchronous direction pin: 1 down, 0 up |
| subclk_en | input | 1 | Sub-clock divide-by-4 enable, synchronous to clk |
| irq_flag | output | 1 | Sticky wrap flag |

## Verification
A mode write shows on the read port one edge later. Prescaler and sub-clock ticks change the counter and flag on the same edge that sees the enable. Event and direction-pin changes take effect on the third edge, after two synchronizer flops and the edge register. The bench drives inputs just after a falling edge and samples just before the next rising edge. Its cycle-accurate reference model advances on the same rising edges as the design, so each cycle's comparison sees the result due in that cycle. Directed checks count the exact edges: 8191 versus 8192 after reset for the slowest tap, and two versus three edges after an event change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned PSC_W  = 13;
  localparam int unsigned N_TAPS = 6;
  localparam int unsigned REG_W  = 8;

  typedef enum logic [2:0] {
    SRC_D8192 = 3'd0,
    SRC_D2048 = 3'd1,
    SRC_D512  = 3'd2,
    SRC_D64   = 3'd3,
    SRC_D16   = 3'd4,
    SRC_D4    = 3'd5,
    SRC_SUB   = 3'd6,
    SRC_EVT   = 3'd7
  } clk_src_e;

  // log2 of the division ratio for each prescaler tap
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 13;
      1:       return 11;
      2:       return 9;
      3:       return 6;
      4:       return 4;
      default: return 2;
    endcase
  endfunction

  // mode register: bits [4:3] read as one, bit 7 as zero
  localparam logic [REG_W-1:0] MODE_RSV_ONES = 8'h18;
  localparam logic [REG_W-1:0] MODE_WR_MASK  = 8'h67;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned W     = PSC_W,
  parameter int unsigned TAPS  = N_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tap_pulse
);

  logic [W-1:0] psc_q;
  logic [W-1:0] psc_d;

  always_comb begin
    psc_d = psc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // a tap fires on the edge where its low bits roll over
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam int unsigned SH = tap_shift(i);
    assign tap_pulse[i] = &psc_q[SH-1:0];
  end

endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic pol_rise,
  output logic edge_pulse
);

  logic lvl_s;
  logic prev_q;

  tmr_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .dout (lvl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_s;
  end

  always_comb begin
    if (pol_rise) edge_pulse = lvl_s & ~prev_q;
    else          edge_pulse = ~lvl_s & prev_q;
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         down,
  output logic [W-1:0] count,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (tick) begin
      if (down) begin
        cnt_d = cnt_q - W'(1);
        wrap  = (cnt_q == '0);
      end else begin
        cnt_d = cnt_q + W'(1);
        wrap  = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/updn_event_timer.sv
module updn_event_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             flag_clr,
  input  logic             ext_evt,
  input  logic             evt_rise,
  input  logic             ud_pin,
  input  logic             subclk_en,
  output logic             irq_flag
);

  logic [REG_W-1:0]  mode_q;
  logic [REG_W-1:0]  mode_d;
  clk_src_e          src_sel;
  logic [1:0]        dir_sel;
  logic [N_TAPS-1:0] tap_pulse;
  logic              evt_pulse;
  logic              ud_s;
  logic              cnt_tick;
  logic              cnt_down;
  logic              cnt_wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q;
  logic              flag_d;

  // mode register
  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = (wr_data & MODE_WR_MASK) | MODE_RSV_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RSV_ONES;
    else        mode_q <= mode_d;
  end

  assign src_sel = clk_src_e'(mode_q[2:0]);
  assign dir_sel = mode_q[6:5];

  tmr_prescaler #(.W(PSC_W), .TAPS(N_TAPS)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_pulse(tap_pulse)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (ext_evt),
    .pol_rise  (evt_rise),
    .edge_pulse(evt_pulse)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_ud (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ud_pin),
    .dout (ud_s)
  );

  // count enable source
  always_comb begin
    case (src_sel)
      SRC_D8192: cnt_tick = tap_pulse[0];
      SRC_D2048: cnt_tick = tap_pulse[1];
      SRC_D512:  cnt_tick = tap_pulse[2];
      SRC_D64:   cnt_tick = tap_pulse[3];
      SRC_D16:   cnt_tick = tap_pulse[4];
      SRC_D4:    cnt_tick = tap_pulse[5];
      SRC_SUB:   cnt_tick = subclk_en;
      default:   cnt_tick = evt_pulse;
    endcase
  end

  // direction: bit 1 hands control to the pin
  always_comb begin
    if (dir_sel[1]) cnt_down = ud_s;
    else            cnt_down = dir_sel[0];
  end

  tmr_count_core #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (cnt_tick),
    .down (cnt_down),
    .count(cnt_q),
    .wrap (cnt_wrap)
  );

  // sticky wrap flag, set dominates clear
  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (cnt_wrap) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_flag = flag_q;

  always_comb begin
    if (rd_addr) rd_data = REG_W'(cnt_q);
    else         rd_data = mode_q;
  end

endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             down,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             flag_clr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_addr,
  input logic [7:0]       rd_data
);

  logic at_top;
  logic at_bot;
  assign at_top = &count;
  assign at_bot = (count == '0);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !down && !at_top |=> count == CNT_W'($past(count) + CNT_W'(1)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && down && !at_bot |=> count == CNT_W'($past(count) - CNT_W'(1)));

  // R8
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !down && at_top |=> count == '0 && flag);

  // R8
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && down && at_bot |=> at_top && flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !(tick && (down ? at_bot : at_top)) |=> !flag);

  // R2
  mode_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> rd_data[4:3] == 2'b11 && !rd_data[7]);

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_addr ##1 !rd_addr |-> rd_data[6:5] == $past(wr_data[6:5])
                                     && rd_data[2:0] == $past(wr_data[2:0]));

endmodule

bind updn_event_timer tmr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (cnt_tick),
  .down    (cnt_down),
  .count   (cnt_q),
  .flag    (irq_flag),
  .flag_clr(flag_clr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/sim_updn_event_timer.sv
`timescale 1ns/1ps
module sim_updn_event_timer;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_addr;
  logic [7:0] rd_data;
  logic       flag_clr;
  logic       ext_evt;
  logic       evt_rise;
  logic       ud_pin;
  logic       subclk_en;
  logic       irq_flag;

  int n_tests;
  int n_fail;
  bit done;

  updn_event_timer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .flag_clr (flag_clr),
    .ext_evt  (ext_evt),
    .evt_rise (evt_rise),
    .ud_pin   (ud_pin),
    .subclk_en(subclk_en),
    .irq_flag (irq_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model built from the requirements
  logic [12:0] m_psc;
  logic [1:0]  m_dir;
  logic [2:0]  m_src;
  logic [2:0]  m_evt;
  logic [1:0]  m_ud;
  logic [7:0]  m_cnt;
  logic        m_flag;

  function automatic bit model_tick(logic [2:0] src, logic [12:0] psc,
                                    logic sub, logic [2:0] ev, logic rise);
    int sh;
    case (src)
      3'd0: sh = 13;
      3'd1: sh = 11;
      3'd2: sh = 9;
      3'd3: sh = 6;
      3'd4: sh = 4;
      3'd5: sh = 2;
      3'd6: return sub;
      default: return rise ? (ev[1] & ~ev[2]) : (~ev[1] & ev[2]);
    endcase
    return ((psc & ((13'd1 << sh) - 13'd1)) == ((13'd1 << sh) - 13'd1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psc <= '0; m_dir <= '0; m_src <= '0; m_evt <= '0; m_ud <= '0;
      m_cnt <= '0; m_flag <= 1'b0;
    end else begin
      bit t, dn, wr;
      t  = model_tick(m_src, m_psc, subclk_en, m_evt, evt_rise);
      dn = m_dir[1] ? m_ud[1] : m_dir[0];
      wr = t && (dn ? (m_cnt == 8'h00) : (m_cnt == 8'hFF));
      m_psc <= m_psc + 13'd1;
      m_evt <= {m_evt[1:0], ext_evt};
      m_ud  <= {m_ud[0], ud_pin};
      if (wr_en) begin m_dir <= wr_data[6:5]; m_src <= wr_data[2:0]; end
      if (t) m_cnt <= dn ? m_cnt - 8'd1 : m_cnt + 8'd1;
      if (wr) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd_cnt(output logic [7:0] v);
    rd_addr = 1'b1; #1; v = rd_data;
  endtask

  task automatic cmp_model(string tag);
    logic [7:0] v;
    rd_cnt(v);
    chk({tag, " count"}, v, m_cnt);
    chk({tag, " flag"}, {7'd0, irq_flag}, {7'd0, m_flag});
  endtask

  task automatic write_mode(logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cmp(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model(tag);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, base;
    void'($urandom(32'd20240611));
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_addr = 1'b0;
    flag_clr = 1'b0; ext_evt = 1'b0; evt_rise = 1'b1; ud_pin = 1'b0; subclk_en = 1'b0;
    #23;
    @(negedge clk);
    // R1 reset state
    rd_addr = 1'b0; #1; chk("R1 mode", rd_data, 8'h18);
    rd_cnt(v);           chk("R1 count", v, 8'h00);
    chk("R1 flag", {7'd0, irq_flag}, 8'h00);
    rst_n = 1'b1;

    // R5 divide by 8192 from reset: 8191 edges -> 0, 8192 -> 1
    repeat (8191) @(negedge clk);
    rd_cnt(v); chk("R5 d8192 edge 8191", v, 8'h00);
    @(negedge clk);
    rd_cnt(v); chk("R5 d8192 edge 8192", v, 8'h01);

    // R2 reserved bits and mode layout
    write_mode(8'h85);
    rd_addr = 1'b0; #1; chk("R2 rsv/bit7 ignored", rd_data, 8'h1D);
    write_mode(8'h00);
    rd_addr = 1'b0; #1; chk("R2 rewrite", rd_data, 8'h18);

    // R3 up then down on divide by 4 and 16
    write_mode(8'h05);
    run_cmp("R3 up d4", 40);
    write_mode(8'h24);
    run_cmp("R3 down d16", 80);
    // R5 other taps
    write_mode(8'h03);
    run_cmp("R5 d64", 200);

    // R4 direction from the pin
    write_mode(8'h45);
    @(negedge clk); ud_pin = 1'b1;
    run_cmp("R4 pin high", 30);
    ud_pin = 1'b0;
    run_cmp("R4 pin low", 30);
    write_mode(8'h65);
    ud_pin = 1'b1;
    run_cmp("R4 code 11", 20);

    // R6 sub-clock enable
    write_mode(8'h06);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); subclk_en = (i % 3 != 0);
      cmp_model("R6 subclk");
    end
    subclk_en = 1'b0;

    // R7 exact latency of an event edge
    write_mode(8'h07);
    evt_rise = 1'b1;
    repeat (4) @(negedge clk);
    rd_cnt(base);
    ext_evt = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_cnt(v); chk("R7 rise after 2 edges", v, base);
    @(negedge clk);
    rd_cnt(v); chk("R7 rise after 3 edges", v, base + 8'd1);
    evt_rise = 1'b0;
    run_cmp("R7 fall select", 3);
    ext_evt = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd_cnt(v); chk("R7 falling edge counted", v, base + 8'd2);
    evt_rise = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (i % 4 == 0) ext_evt = ~ext_evt;
      cmp_model("R7 event");
    end

    // R8 down wrap from 0 via sub-clock
    write_mode(8'h26);
    rd_cnt(v);
    while (v != 8'h00) begin
      @(negedge clk); subclk_en = 1'b1;
      @(negedge clk); subclk_en = 1'b0; rd_cnt(v);
    end
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 clear", {7'd0, irq_flag}, 8'h00);
    // R9 wrap and clear together: set wins
    subclk_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk); subclk_en = 1'b0; flag_clr = 1'b0;
    rd_cnt(v); chk("R8 down wrap to FF", v, 8'hFF);
    chk("R9 set beats clear", {7'd0, irq_flag}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R9 sticky", {7'd0, irq_flag}, 8'h01);
    rd_cnt(v); chk("R10 hold", v, 8'hFF);
    // R8 up wrap
    write_mode(8'h06);
    flag_clr = 1'b1; subclk_en = 1'b1;
    @(negedge clk); flag_clr = 1'b0; subclk_en = 1'b0;
    rd_cnt(v); chk("R8 up wrap to 00", v, 8'h00);
    chk("R8 up wrap flag", {7'd0, irq_flag}, 8'h01);

    // constrained random mix against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 64 == 0);
      wr_data = 8'($urandom) | 8'h04;
      if ($urandom % 8 == 0) wr_data[2:0] = 3'($urandom % 8);
      if ($urandom % 5 == 0) ext_evt = ~ext_evt;
      if ($urandom % 16 == 0) ud_pin = ~ud_pin;
      if ($urandom % 200 == 0) evt_rise = ~evt_rise;
      subclk_en = ($urandom % 3 == 0);
      flag_clr = ($urandom % 20 == 0);
      cmp_model("R10 random");
    end
    @(negedge clk);
    wr_en = 1'b0; flag_clr = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule